// File: doc/BRIEF.md
# Architectural Checkpoint and Rollback Sequencer

This block takes a snapshot of a processor core's architectural state and later restores it, so that a long experiment can be run repeatedly from the same starting point. The state model is a small array of words. The low words hold the general registers, then the program counters, then the trap stack entries. The block reads and writes these words through a simple indexed port. The shadow copy is held inside the block.

A save request first waits for the core to go quiet: the pipeline must be empty and the load/store queues must be empty. The block then reads every architectural word into its shadow bank, one word per cycle. Next it asks for the L1 caches and TLBs to be invalidated. Last, it hands over to an external agent that snapshots memory. The save counts as complete only after that agent acknowledges.

A rollback request works in a different order. It first holds the core in reset for a fixed number of cycles. It then writes the shadow words back, invalidates the caches and TLBs, and synchronizes with the memory agent. A rollback is refused when no completed save exists. Issue is stalled for as long as either operation is in progress.

Top module: `ckpt_rollback_ctrl`

## Requirements
- R1: After reset the block is idle. `stall_o`, `err_o`, `ckpt_valid_o`, `core_rst_o`, `arch_rd_en_o`, `arch_wr_en_o`, `inval_o`, `mem_req_o` and `done_o` are all 0.
- R2: After a save request is accepted, no architectural word is read until a clock edge at which both `pipe_empty_i` and `lsq_empty_i` are 1.
- R3: A save reads words 0 to NWORDS-1 in ascending order, one per cycle with `arch_rd_en_o` high, and stores them in the shadow bank.
- R4: A rollback holds `core_rst_o` high for exactly CORE_RST_CYCLES cycles. It then writes the shadow words back in ascending index order, one per cycle with `arch_wr_en_o` high. Afterwards the core holds the values captured by the last save.
- R5: Both operations assert `inval_o` after the copy phase and hold it until the clock edge that samples `inval_done_i` high. `inval_o` is therefore high for L+2 cycles when the agent raises `inval_done_i` L+1 edges after `inval_o` rises.
- R6: After invalidation, `mem_req_o` is held with a stable `mem_op_o` (0 = save, 1 = rollback) until `mem_ack_i` is sampled high. The next cycle carries a single-cycle `done_o` pulse, with `done_op_o` giving the same encoding.
- R7: `ckpt_valid_o` rises on the edge that ends the `done_o` cycle of a save, and never otherwise. Rollbacks leave it set.
- R8: `stall_o` is high from the cycle after a request is accepted through the `done_o` cycle, and low when idle.
- R9: A rollback request while `ckpt_valid_o` is 0 is rejected. `err_o` goes high the next cycle and no reset, read, write or handshake follows. `err_o` clears when a later request is accepted.
- R10: Requests that arrive while the block is busy are ignored. When both requests arrive together while idle, the save is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ckpt_req_i | input | 1 | Save request, sampled while idle |
| rest_req_i | input | 1 | Rollback request, sampled while idle |
| pipe_empty_i | input | 1 | No instruction active in the pipeline |
| lsq_empty_i | input | 1 | All load/store queues empty |
| stall_o | output | 1 | Hold instruction issue |
| core_rst_o | output | 1 | Reset to the core during rollback |
| arch_rd_en_o | output | 1 | Architectural word read strobe |
| arch_rd_idx_o | output | $clog2(NWORDS) | Index of word being read |
| arch_rd_data_i | input | DATA_W | Read data for `arch_rd_idx_o` |
| arch_wr_en_o | output | 1 | Architectural word write strobe |
| arch_wr_idx_o | output | $clog2(NWORDS) | Index of word being written |
| arch_wr_data_o | output | DATA_W | Shadow word written back |
| inval_o | output | 1 | Invalidate L1 caches and TLBs |
| inval_done_i | input | 1 | Invalidation finished |
| mem_req_o | output | 1 | Request to memory-snapshot agent |
| mem_op_o | output | 1 | 0 = snapshot memory, 1 = restore memory |
| mem_ack_i | input | 1 | Memory agent finished |
| done_o | output | 1 | Operation complete pulse |
| done_op_o | output | 1 | Which operation completed (0 save, 1 rollback) |
| ckpt_valid_o | output | 1 | A completed save exists |
| err_o | output | 1 | Last rollback request was rejected |

## Verification
The assertions assume that the core keeps its architectural words still while `stall_o` is high. They also assume that `inval_done_i` and `mem_ack_i` arrive only while the matching request is high. The bench models the core and both agents to match these assumptions. It changes the core's words only while idle. Its responders raise each completion strobe for one cycle, a random number of cycles after the request rises. The queue-empty inputs are held low only before the copy phase starts, so the drain gate is exercised without the queues refilling under a stall.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  typedef int unsigned uint_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_COPY,
    ST_RESET,
    ST_COPYBACK,
    ST_INVAL,
    ST_MSYNC,
    ST_DONE
  } seq_state_e;

  typedef enum logic {
    OP_SAVE     = 1'b0,
    OP_ROLLBACK = 1'b1
  } seq_op_e;

  function automatic logic idx_is_last(input uint_t idx, input uint_t count);
    return idx == count - 1;
  endfunction

  function automatic uint_t word_count(input uint_t gpr, input uint_t pcs, input uint_t traps);
    return gpr + pcs + traps;
  endfunction
endpackage

// File: rtl/ckpt_shadow_bank.sv
module ckpt_shadow_bank
  import ckpt_pkg::*;
#(
  parameter uint_t DATA_W = 32,
  parameter uint_t NWORDS = 14,
  localparam int   IDXW   = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDXW-1:0]   widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDXW-1:0]   ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we_i && widx_i == IDXW'(g)) q <= wdata_i;
    end
    assign words[g] = q;
  end

  assign rdata_o = (uint_t'(ridx_i) < NWORDS) ? words[ridx_i] : '0;

  // R3
  shadow_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> uint_t'(widx_i) < NWORDS);
endmodule

// File: rtl/ckpt_sequencer.sv
module ckpt_sequencer
  import ckpt_pkg::*;
#(
  parameter uint_t NWORDS    = 14,
  parameter uint_t RST_CYC   = 3,
  localparam int   IDXW      = $clog2(NWORDS),
  localparam int   RCW       = $clog2(RST_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ckpt_req_i,
  input  logic            rest_req_i,
  input  logic            pipe_empty_i,
  input  logic            lsq_empty_i,
  input  logic            inval_done_i,
  input  logic            mem_ack_i,
  output logic            stall_o,
  output logic            core_rst_o,
  output logic            rd_en_o,
  output logic            wr_en_o,
  output logic [IDXW-1:0] idx_o,
  output logic            inval_o,
  output logic            mem_req_o,
  output logic            mem_op_o,
  output logic            done_o,
  output logic            done_op_o,
  output logic            ckpt_valid_o,
  output logic            err_o
);
  seq_state_e      st_q;
  seq_op_e         op_q;
  logic [IDXW-1:0] idx_q;
  logic [RCW-1:0]  rcnt_q;
  logic            valid_q;
  logic            err_q;

  // named internal events
  logic idle, drained, copy_last, rst_last, accept_save, accept_roll, reject_roll;
  assign idle        = (st_q == ST_IDLE);
  assign drained     = pipe_empty_i && lsq_empty_i;
  assign copy_last   = idx_is_last(uint_t'(idx_q), NWORDS);
  assign rst_last    = (rcnt_q == RCW'(RST_CYC - 1));
  assign accept_save = idle && ckpt_req_i;
  assign accept_roll = idle && !ckpt_req_i && rest_req_i && valid_q;
  assign reject_roll = idle && !ckpt_req_i && rest_req_i && !valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_SAVE;
      idx_q   <= '0;
      rcnt_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept_save) begin
            st_q  <= ST_DRAIN;
            op_q  <= OP_SAVE;
            err_q <= 1'b0;
          end else if (accept_roll) begin
            st_q   <= ST_RESET;
            op_q   <= OP_ROLLBACK;
            err_q  <= 1'b0;
            rcnt_q <= '0;
          end else if (reject_roll) begin
            err_q <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drained) begin
            st_q  <= ST_COPY;
            idx_q <= '0;
          end
        end
        ST_COPY: begin
          if (copy_last) begin
            st_q  <= ST_INVAL;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + IDXW'(1);
          end
        end
        ST_RESET: begin
          if (rst_last) begin
            st_q  <= ST_COPYBACK;
            idx_q <= '0;
          end else begin
            rcnt_q <= rcnt_q + RCW'(1);
          end
        end
        ST_COPYBACK: begin
          if (copy_last) begin
            st_q  <= ST_INVAL;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + IDXW'(1);
          end
        end
        ST_INVAL: if (inval_done_i) st_q <= ST_MSYNC;
        ST_MSYNC: if (mem_ack_i) st_q <= ST_DONE;
        ST_DONE: begin
          st_q <= ST_IDLE;
          if (op_q == OP_SAVE) valid_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign stall_o      = !idle;
  assign core_rst_o   = (st_q == ST_RESET);
  assign rd_en_o      = (st_q == ST_COPY);
  assign wr_en_o      = (st_q == ST_COPYBACK);
  assign idx_o        = idx_q;
  assign inval_o      = (st_q == ST_INVAL);
  assign mem_req_o    = (st_q == ST_MSYNC);
  assign mem_op_o     = op_q;
  assign done_o       = (st_q == ST_DONE);
  assign done_op_o    = op_q;
  assign ckpt_valid_o = valid_q;
  assign err_o        = err_q;

  // R2
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en_o) |-> $past(pipe_empty_i && lsq_empty_i));
  // R4
  rst_before_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en_o) |-> $past(core_rst_o));
  // R5
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en_o, wr_en_o, core_rst_o, inval_o, mem_req_o, done_o}));
  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_op_o)));
  // R6
  done_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(mem_req_o && mem_ack_i));
  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ckpt_valid_o) |-> $past(done_o && done_op_o == OP_SAVE));
  // R8
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o || wr_en_o || core_rst_o || inval_o || mem_req_o || done_o) |-> stall_o);
  // R9
  reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!ckpt_valid_o && !stall_o));
endmodule

// File: rtl/ckpt_rollback_ctrl.sv
module ckpt_rollback_ctrl
  import ckpt_pkg::*;
#(
  parameter uint_t DATA_W          = 32,
  parameter uint_t NUM_GPR         = 8,
  parameter uint_t NUM_PC          = 2,
  parameter uint_t TRAP_DEPTH      = 4,
  parameter uint_t CORE_RST_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ckpt_req_i,
  input  logic rest_req_i,
  input  logic pipe_empty_i,
  input  logic lsq_empty_i,
  output logic stall_o,
  output logic core_rst_o,
  output logic arch_rd_en_o,
  output logic [$clog2(NUM_GPR+NUM_PC+TRAP_DEPTH)-1:0] arch_rd_idx_o,
  input  logic [DATA_W-1:0] arch_rd_data_i,
  output logic arch_wr_en_o,
  output logic [$clog2(NUM_GPR+NUM_PC+TRAP_DEPTH)-1:0] arch_wr_idx_o,
  output logic [DATA_W-1:0] arch_wr_data_o,
  output logic inval_o,
  input  logic inval_done_i,
  output logic mem_req_o,
  output logic mem_op_o,
  input  logic mem_ack_i,
  output logic done_o,
  output logic done_op_o,
  output logic ckpt_valid_o,
  output logic err_o
);
  localparam uint_t NWORDS = word_count(NUM_GPR, NUM_PC, TRAP_DEPTH);
  localparam int    IDXW   = $clog2(NWORDS);

  logic            rd_en, wr_en;
  logic [IDXW-1:0] idx;

  ckpt_sequencer #(
    .NWORDS (NWORDS),
    .RST_CYC(CORE_RST_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ckpt_req_i  (ckpt_req_i),
    .rest_req_i  (rest_req_i),
    .pipe_empty_i(pipe_empty_i),
    .lsq_empty_i (lsq_empty_i),
    .inval_done_i(inval_done_i),
    .mem_ack_i   (mem_ack_i),
    .stall_o     (stall_o),
    .core_rst_o  (core_rst_o),
    .rd_en_o     (rd_en),
    .wr_en_o     (wr_en),
    .idx_o       (idx),
    .inval_o     (inval_o),
    .mem_req_o   (mem_req_o),
    .mem_op_o    (mem_op_o),
    .done_o      (done_o),
    .done_op_o   (done_op_o),
    .ckpt_valid_o(ckpt_valid_o),
    .err_o       (err_o)
  );

  ckpt_shadow_bank #(
    .DATA_W(DATA_W),
    .NWORDS(NWORDS)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (rd_en),
    .widx_i (idx),
    .wdata_i(arch_rd_data_i),
    .ridx_i (idx),
    .rdata_o(arch_wr_data_o)
  );

  assign arch_rd_en_o  = rd_en;
  assign arch_rd_idx_o = idx;
  assign arch_wr_en_o  = wr_en;
  assign arch_wr_idx_o = idx;
endmodule

// File: tb/sim_ckpt_rollback_ctrl.sv
`timescale 1ns/1ps
module sim_ckpt_rollback_ctrl;
  localparam int W = 32, NG = 8, NP = 2, NT = 4, RC = 3;
  localparam int N = NG + NP + NT;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ckpt_req_i, rest_req_i, pipe_empty_i, lsq_empty_i;
  logic stall_o, core_rst_o, arch_rd_en_o, arch_wr_en_o, inval_o, inval_done_i;
  logic mem_req_o, mem_op_o, mem_ack_i, done_o, done_op_o, ckpt_valid_o, err_o;
  logic [IW-1:0] arch_rd_idx_o, arch_wr_idx_o;
  logic [W-1:0]  arch_rd_data_i, arch_wr_data_o;

  ckpt_rollback_ctrl #(.DATA_W(W), .NUM_GPR(NG), .NUM_PC(NP), .TRAP_DEPTH(NT),
                       .CORE_RST_CYCLES(RC)) u0 (.*);

  // core model
  logic [W-1:0] arch [N];
  logic [W-1:0] load_vals [N];
  logic         load_now = 1'b0;
  assign arch_rd_data_i = arch[arch_rd_idx_o];
  always @(posedge clk) begin
    if (load_now) for (int k = 0; k < N; k++) arch[k] <= load_vals[k];
    else if (arch_wr_en_o) arch[arch_wr_idx_o] <= arch_wr_data_o;
    else if (core_rst_o) for (int k = 0; k < N; k++) arch[k] <= '0;
  end

  // agents
  int ilat = 0, mlat = 0, icnt = 0, mcnt = 0;
  always @(posedge clk) begin
    if (!inval_o) begin icnt <= 0; inval_done_i <= 1'b0; end
    else begin icnt <= icnt + 1; inval_done_i <= (icnt == ilat); end
    if (!mem_req_o) begin mcnt <= 0; mem_ack_i <= 1'b0; end
    else begin mcnt <= mcnt + 1; mem_ack_i <= (mcnt == mlat); end
  end

  // monitor
  int rd_cnt = 0, wr_cnt = 0, rst_cnt = 0, inv_cyc = 0, mem_cyc = 0, done_cnt = 0;
  int seq_bad = 0, memop_bad = 0, drain_bad = 0, rd_run = 0, wr_run = 0;
  logic cur_op = 1'b0;
  always @(negedge clk) begin
    if (arch_rd_en_o) begin
      rd_cnt <= rd_cnt + 1;
      if (int'(arch_rd_idx_o) != rd_run) seq_bad <= seq_bad + 1;
      if (!(pipe_empty_i && lsq_empty_i)) drain_bad <= drain_bad + 1;
      rd_run <= rd_run + 1;
    end else rd_run <= 0;
    if (arch_wr_en_o) begin
      wr_cnt <= wr_cnt + 1;
      if (int'(arch_wr_idx_o) != wr_run) seq_bad <= seq_bad + 1;
      wr_run <= wr_run + 1;
    end else wr_run <= 0;
    if (core_rst_o) rst_cnt <= rst_cnt + 1;
    if (inval_o) inv_cyc <= inv_cyc + 1;
    if (mem_req_o) begin
      mem_cyc <= mem_cyc + 1;
      if (mem_op_o != cur_op) memop_bad <= memop_bad + 1;
    end
    if (done_o) done_cnt <= done_cnt + 1;
  end

  int vectors = 0, fails = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  logic [W-1:0] model [N];
  logic [W-1:0] snap [N];

  task automatic scramble();
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      load_vals[k] = $urandom;
      model[k] = load_vals[k];
    end
    load_now = 1'b1;
    @(negedge clk);
    load_now = 1'b0;
  endtask

  function automatic int core_mismatches();
    int m = 0;
    for (int k = 0; k < N; k++) if (arch[k] !== snap[k]) m++;
    return m;
  endfunction

  function automatic int exp_handshake_cycles(input int lat);
    return lat + 2;
  endfunction

  // is_rest: rollback; both: raise both requests; drain: cycles to hold queues busy
  task automatic run_op(input bit is_rest, input bit both, input int drain,
                        input bit use_pipe, input bit poke);
    int b_rd, b_wr, b_rst, b_inv, b_mem, b_done, b_seq, b_mop, b_dr;
    bit seen = 0;
    bit eff_rest;
    eff_rest = is_rest && !both;
    ilat = $urandom_range(0, 4);
    mlat = $urandom_range(0, 4);
    cur_op = eff_rest;
    @(negedge clk);
    b_rd = rd_cnt; b_wr = wr_cnt; b_rst = rst_cnt; b_inv = inv_cyc; b_mem = mem_cyc;
    b_done = done_cnt; b_seq = seq_bad; b_mop = memop_bad; b_dr = drain_bad;
    if (drain > 0) begin
      if (use_pipe) pipe_empty_i = 1'b0; else lsq_empty_i = 1'b0;
    end
    ckpt_req_i = !is_rest || both;
    rest_req_i = is_rest || both;
    @(negedge clk);
    ckpt_req_i = 1'b0; rest_req_i = 1'b0;
    chk(stall_o == 1'b1, "R8", "stall after accept", stall_o, 1);
    chk(err_o == 1'b0, "R9", "err cleared on accept", err_o, 0);
    if (drain > 0) begin
      repeat (drain) @(negedge clk);
      chk(rd_cnt == b_rd, "R2", "no read while queues busy", rd_cnt - b_rd, 0);
      pipe_empty_i = 1'b1; lsq_empty_i = 1'b1;
    end
    for (int t = 0; t < 500 && !seen; t++) begin
      if (poke && t == 1) begin
        if (eff_rest) ckpt_req_i = 1'b1; else rest_req_i = 1'b1;
      end
      if (poke && t == 2) begin ckpt_req_i = 1'b0; rest_req_i = 1'b0; end
      if (done_o) seen = 1;
      else @(negedge clk);
    end
    ckpt_req_i = 1'b0; rest_req_i = 1'b0;
    chk(seen, "R6", "done seen", seen, 1);
    chk(done_op_o == eff_rest, "R10", "done op", done_op_o, eff_rest);
    @(negedge clk);
    chk(stall_o == 1'b0, "R8", "idle after done", stall_o, 0);
    chk(done_cnt - b_done == 1, "R6", "single done pulse", done_cnt - b_done, 1);
    chk(memop_bad == b_mop, "R6", "mem op encoding", memop_bad - b_mop, 0);
    chk(mem_cyc - b_mem == exp_handshake_cycles(mlat), "R6", "mem req cycles",
        mem_cyc - b_mem, exp_handshake_cycles(mlat));
    chk(inv_cyc - b_inv == exp_handshake_cycles(ilat), "R5", "inval cycles",
        inv_cyc - b_inv, exp_handshake_cycles(ilat));
    chk(seq_bad == b_seq, "R3", "ascending index order", seq_bad - b_seq, 0);
    chk(drain_bad == b_dr, "R2", "read with queues busy", drain_bad - b_dr, 0);
    if (!eff_rest) begin
      chk(rd_cnt - b_rd == N, "R3", "words read", rd_cnt - b_rd, N);
      chk(rst_cnt == b_rst, "R3", "no core reset on save", rst_cnt - b_rst, 0);
      chk(ckpt_valid_o == 1'b1, "R7", "valid after save", ckpt_valid_o, 1);
      for (int k = 0; k < N; k++) snap[k] = model[k];
    end else begin
      chk(rst_cnt - b_rst == RC, "R4", "core reset cycles", rst_cnt - b_rst, RC);
      chk(wr_cnt - b_wr == N, "R4", "words written", wr_cnt - b_wr, N);
      chk(core_mismatches() == 0, "R4", "restored words", core_mismatches(), 0);
      chk(ckpt_valid_o == 1'b1, "R7", "valid kept by rollback", ckpt_valid_o, 1);
      for (int k = 0; k < N; k++) model[k] = snap[k];
    end
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(stall_o == 1'b0, "R10", "busy request ignored", stall_o, 0);
    end
  endtask

  initial begin
    int b_rst, b_rd;
    void'($urandom(32'h1c0ffee));
    rst_n = 1'b0; ckpt_req_i = 1'b0; rest_req_i = 1'b0;
    pipe_empty_i = 1'b1; lsq_empty_i = 1'b1;
    repeat (3) @(negedge clk);
    chk({stall_o, err_o, ckpt_valid_o, core_rst_o, arch_rd_en_o, arch_wr_en_o,
         inval_o, mem_req_o, done_o} == '0, "R1", "reset outputs",
        {stall_o, err_o, ckpt_valid_o, core_rst_o, arch_rd_en_o, arch_wr_en_o,
         inval_o, mem_req_o, done_o}, 0);
    rst_n = 1'b1;
    scramble();

    // R9: rollback before any save
    b_rst = rst_cnt; b_rd = wr_cnt;
    rest_req_i = 1'b1;
    @(negedge clk);
    rest_req_i = 1'b0;
    chk(err_o == 1'b1, "R9", "reject flag", err_o, 1);
    chk(stall_o == 1'b0, "R9", "no stall on reject", stall_o, 0);
    repeat (4) @(negedge clk);
    chk(rst_cnt == b_rst && wr_cnt == b_rd, "R9", "no activity on reject",
        (rst_cnt - b_rst) + (wr_cnt - b_rd), 0);
    chk(ckpt_valid_o == 1'b0, "R7", "valid still low", ckpt_valid_o, 0);

    run_op(1'b0, 1'b0, 10, 1'b0, 1'b0);   // R2 drain on queues
    scramble();
    run_op(1'b1, 1'b0, 0, 1'b0, 1'b0);    // rollback
    scramble();
    run_op(1'b0, 1'b0, 6, 1'b1, 1'b0);    // R2 drain on pipeline
    scramble();
    run_op(1'b0, 1'b1, 0, 1'b0, 1'b0);    // R10 both at once
    scramble();
    run_op(1'b1, 1'b0, 0, 1'b0, 1'b1);    // R10 poke during rollback
    run_op(1'b0, 1'b0, 0, 1'b0, 1'b1);    // R10 poke during save

    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 1) == 1) scramble();
      run_op($urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
             $urandom_range(0, 3) == 0 ? int'($urandom_range(1, 6)) : 0,
             $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule